// File: doc/BRIEF.md
# Power-up Reset Sequencing Controller

This block produces the active-low core reset of a device from four sources: a power-on event, a brown-out flag, an external active-low reset pin and a watchdog expiry strobe. Power-on and brown-out are the slow sources. After either one, reset is stretched by a power-up delay counter that advances once per tick of a low-frequency oscillator, near 31 kHz. The default count of 1984 ticks gives roughly 64 ms. A configuration input can skip this delay. The pin and watchdog sources are fast: they hold reset only while they are active and never start the delay counter.

The pin passes through a two-flop synchronizer and then a glitch filter. The filter rejects any low pulse shorter than `FILT_LEN` consecutive clock samples. A configuration input can disconnect the pin entirely; the filter input is then tied inactive and a weak pull-up enable is raised. The watchdog path only reaches the core reset and never acts on the pin. A one-hot cause register records which source started the latest reset. The core reset asserts asynchronously and releases through two flops synchronous to `clk`.

The sequencer is a state machine with four states:
- `ST_DELAY`: the counter is running. This is the state after power-on.
- `ST_BOR_HOLD`: a brown-out is being held.
- `ST_EXT_HOLD`: a pin or watchdog reset is being held.
- `ST_RUN`: reset is released.

Transitions:
- ST_DELAY→ST_RUN when the counter completes or the delay is skipped.
- Any state→ST_BOR_HOLD while `brownout` is high.
- ST_BOR_HOLD→ST_DELAY when `brownout` falls.
- ST_RUN→ST_EXT_HOLD on a filtered pin low or a watchdog strobe.
- ST_EXT_HOLD→ST_RUN once both of those are gone.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `pwr_on` is high and after it falls, reset is held and `rst_cause` reads 4'b0001 (bit 0 power-on, bit 1 brown-out, bit 2 pin, bit 3 watchdog; exactly one bit set).
- R2: With `delay_skip` low, reset releases only after exactly `DELAY_TICKS` `lf_tick` pulses have been seen in ST_DELAY.
- R3: With `delay_skip` high, reset releases after power-on or brown-out without any `lf_tick` pulse.
- R4: While `brownout` is high, reset is held whatever ticks arrive, and `rst_cause` reads 4'b0010.
- R5: A brown-out during the delay restarts the count from zero, so a full `DELAY_TICKS` ticks are needed after it ends.
- R6: A low on `ext_rst_n` lasting `FILT_LEN-1` clocks causes no reset. A low lasting `FILT_LEN` clocks causes a reset with `rst_cause` 4'b0100, and reset releases without the delay once the pin is high again.
- R7: With `ext_pin_en` low, any level on `ext_rst_n` has no effect on the core reset, and `ext_pull_en` is high. With `ext_pin_en` high, `ext_pull_en` is low.
- R8: A one-cycle `wdog_expire` strobe in ST_RUN causes a reset with `rst_cause` 4'b1000, released without the delay.
- R9: `core_rst_n` falls asynchronously, with no clock edge needed, and rises two `clk` edges after the sequencer enters ST_RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwr_on | input | 1 | Power-on event, active high, asynchronous |
| lf_tick | input | 1 | One-cycle strobe per low-frequency oscillator period |
| brownout | input | 1 | Brown-out flag, level, synchronous to clk |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdog_expire | input | 1 | Watchdog expiry strobe, synchronous |
| ext_pin_en | input | 1 | 1: pin is used; 0: pin is ignored and tied inactive |
| delay_skip | input | 1 | 1: skip the power-up delay; 0: apply it |
| core_rst_n | output | 1 | Internal core reset, active low |
| rst_cause | output | 4 | One-hot cause of the latest reset |
| ext_pull_en | output | 1 | Weak pull-up enable for the pin when it is ignored |

## Verification
The delay is exercised by counting ticks one at a time up to one short of the limit and then one more, which distinguishes an off-by-one count from a correct one. A brown-out inserted part way through the count shows whether the counter is cleared or merely paused. Pin lows of `FILT_LEN-1` and `FILT_LEN` clocks bracket the filter threshold exactly, and a long low with the pin disabled separates a true tie-off from a filter that is merely slow. The watchdog strobe and the delay-skip runs show that fast sources and skipped delays release without ticks, and that each source leaves its own cause code.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic [1:0] {
        ST_DELAY    = 2'd0,
        ST_BOR_HOLD = 2'd1,
        ST_EXT_HOLD = 2'd2,
        ST_RUN      = 2'd3
    } rst_state_e;

    localparam int CAUSE_W   = 4;
    localparam int CZ_POWER  = 0;
    localparam int CZ_BROWN  = 1;
    localparam int CZ_PIN    = 2;
    localparam int CZ_WDOG   = 3;

endpackage

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
    parameter int FILT_LEN  = 4,
    parameter int SYNC_LEN  = 2
) (
    input  logic clk,
    input  logic pwr_on,
    input  logic ext_rst_n,
    input  logic ext_pin_en,
    output logic pin_low
);
    localparam int CNT_W = $clog2(FILT_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FILT_LEN);

    logic                pin_eff;
    logic [SYNC_LEN-1:0] sync_q;
    logic [CNT_W-1:0]    cnt_q;

    // pin disconnected: drive the filter with the inactive level
    assign pin_eff = ext_pin_en ? ext_rst_n : 1'b1;

    always_ff @(posedge clk or posedge pwr_on) begin
        if (pwr_on) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_LEN-2:0], pin_eff};
        end
    end

    // consecutive-low counter, saturating at the filter length
    always_ff @(posedge clk or posedge pwr_on) begin
        if (pwr_on) begin
            cnt_q <= '0;
        end else if (sync_q[SYNC_LEN-1]) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign pin_low = (cnt_q == CNT_MAX);

endmodule

// File: rtl/rst_pwrup_timer.sv
module rst_pwrup_timer #(
    parameter int DELAY_TICKS = 1984
) (
    input  logic clk,
    input  logic pwr_on,
    input  logic run,
    input  logic lf_tick,
    output logic done
);
    localparam int CNT_W = $clog2(DELAY_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or posedge pwr_on) begin
        if (pwr_on) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (lf_tick && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = run && lf_tick && (cnt_q == LAST);

endmodule

// File: rtl/rst_release_sync.sv
module rst_release_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic hold,
    output logic rst_n
);
    logic [STAGES-1:0] stage_q;

    always_ff @(posedge clk or posedge hold) begin
        if (hold) begin
            stage_q <= '0;
        end else begin
            stage_q <= {stage_q[STAGES-2:0], 1'b1};
        end
    end

    assign rst_n = stage_q[STAGES-1];

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
    import rst_seq_pkg::*;
#(
    parameter int DELAY_TICKS = 1984,
    parameter int FILT_LEN    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               pwr_on,
    input  logic               lf_tick,
    input  logic               brownout,
    input  logic               ext_rst_n,
    input  logic               wdog_expire,
    input  logic               ext_pin_en,
    input  logic               delay_skip,
    output logic               core_rst_n,
    output logic [CAUSE_W-1:0] rst_cause,
    output logic               ext_pull_en
);
    rst_state_e         state_q;
    rst_state_e         state_nx;
    logic               pin_low;
    logic               delay_done;
    logic               hold_q;
    logic [CAUSE_W-1:0] cause_q;

    rst_pin_filter #(
        .FILT_LEN (FILT_LEN),
        .SYNC_LEN (2)
    ) u_filter (
        .clk        (clk),
        .pwr_on     (pwr_on),
        .ext_rst_n  (ext_rst_n),
        .ext_pin_en (ext_pin_en),
        .pin_low    (pin_low)
    );

    rst_pwrup_timer #(
        .DELAY_TICKS (DELAY_TICKS)
    ) u_timer (
        .clk     (clk),
        .pwr_on  (pwr_on),
        .run     (state_q == ST_DELAY),
        .lf_tick (lf_tick),
        .done    (delay_done)
    );

    // next-state decision; brown-out has top priority
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_DELAY: begin
                if (brownout) begin
                    state_nx = ST_BOR_HOLD;
                end else if (delay_skip || delay_done) begin
                    state_nx = ST_RUN;
                end
            end
            ST_BOR_HOLD: begin
                if (!brownout) begin
                    state_nx = ST_DELAY;
                end
            end
            ST_EXT_HOLD: begin
                if (brownout) begin
                    state_nx = ST_BOR_HOLD;
                end else if (!pin_low && !wdog_expire) begin
                    state_nx = ST_RUN;
                end
            end
            ST_RUN: begin
                if (brownout) begin
                    state_nx = ST_BOR_HOLD;
                end else if (pin_low || wdog_expire) begin
                    state_nx = ST_EXT_HOLD;
                end
            end
            default: state_nx = ST_DELAY;
        endcase
    end

    // state register
    always_ff @(posedge clk or posedge pwr_on) begin
        if (pwr_on) begin
            state_q <= ST_DELAY;
        end else begin
            state_q <= state_nx;
        end
    end

    // outputs: registered hold request and cause record
    always_ff @(posedge clk or posedge pwr_on) begin
        if (pwr_on) begin
            hold_q  <= 1'b1;
            cause_q <= CAUSE_W'(1) << CZ_POWER;
        end else begin
            hold_q <= (state_nx != ST_RUN);
            if (state_nx == ST_BOR_HOLD && state_q != ST_BOR_HOLD) begin
                cause_q <= CAUSE_W'(1) << CZ_BROWN;
            end else if (state_nx == ST_EXT_HOLD && state_q == ST_RUN) begin
                cause_q <= pin_low ? (CAUSE_W'(1) << CZ_PIN)
                                   : (CAUSE_W'(1) << CZ_WDOG);
            end
        end
    end

    rst_release_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .hold  (hold_q),
        .rst_n (core_rst_n)
    );

    assign rst_cause   = cause_q;
    assign ext_pull_en = !ext_pin_en;

endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk
    import rst_seq_pkg::*;
(
    input logic               clk,
    input logic               pwr_on,
    input logic               brownout,
    input logic               wdog_expire,
    input logic               delay_skip,
    input logic               core_rst_n,
    input logic [CAUSE_W-1:0] rst_cause,
    input rst_state_e         state_q,
    input logic               pin_low
);

    assert_cause_onehot_R1: assert property (@(posedge clk) disable iff (pwr_on)
        $countones(rst_cause) == 1);

    assert_bor_holds_R4: assert property (@(posedge clk) disable iff (pwr_on)
        brownout |=> !core_rst_n);

    assert_bor_cause_R4: assert property (@(posedge clk) disable iff (pwr_on)
        brownout |=> rst_cause == 4'b0010);

    assert_skip_delay_R3: assert property (@(posedge clk) disable iff (pwr_on)
        (state_q == ST_DELAY && delay_skip && !brownout) |=> state_q == ST_RUN);

    assert_pin_cause_R6: assert property (@(posedge clk) disable iff (pwr_on)
        (state_q == ST_RUN && pin_low && !brownout) |=> rst_cause == 4'b0100);

    assert_wdog_cause_R8: assert property (@(posedge clk) disable iff (pwr_on)
        (state_q == ST_RUN && wdog_expire && !pin_low && !brownout)
            |=> rst_cause == 4'b1000);

    assert_sync_release_R9: assert property (@(posedge clk) disable iff (pwr_on)
        $rose(core_rst_n) |-> ($past(state_q) == ST_RUN && $past(state_q, 2) == ST_RUN));

endmodule

bind rst_seq_ctrl rst_seq_chk u_chk (
    .clk         (clk),
    .pwr_on      (pwr_on),
    .brownout    (brownout),
    .wdog_expire (wdog_expire),
    .delay_skip  (delay_skip),
    .core_rst_n  (core_rst_n),
    .rst_cause   (rst_cause),
    .state_q     (state_q),
    .pin_low     (pin_low)
);

// File: tb/test_rst_seq_ctrl.sv
module test_rst_seq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DLY        = 40;
    localparam int FLT        = 4;
    localparam int LIMIT      = 100000;

    logic       clk = 1'b0;
    logic       pwr_on = 1'b1;
    logic       lf_tick = 1'b0;
    logic       brownout = 1'b0;
    logic       ext_rst_n = 1'b1;
    logic       wdog_expire = 1'b0;
    logic       ext_pin_en = 1'b1;
    logic       delay_skip = 1'b0;
    logic       core_rst_n;
    logic [3:0] rst_cause;
    logic       ext_pull_en;

    int checks = 0;
    int fails  = 0;
    int low_cnt = 0;
    bit timeout = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (!core_rst_n) low_cnt++;

    rst_seq_ctrl #(.DELAY_TICKS(DLY), .FILT_LEN(FLT)) i_rst_seq_ctrl (
        .clk(clk), .pwr_on(pwr_on), .lf_tick(lf_tick), .brownout(brownout),
        .ext_rst_n(ext_rst_n), .wdog_expire(wdog_expire), .ext_pin_en(ext_pin_en),
        .delay_skip(delay_skip), .core_rst_n(core_rst_n), .rst_cause(rst_cause),
        .ext_pull_en(ext_pull_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) lf_tick = 1'b1;
            @(negedge clk) lf_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    // final tick then sample two-stage release
    task automatic last_tick_release(input string req);
        @(negedge clk) lf_tick = 1'b1;
        @(negedge clk) lf_tick = 1'b0;
        @(negedge clk);
        check({req, " still low one edge after entering run"}, core_rst_n, 1'b0);
        @(negedge clk);
        check({req, " released two edges after entering run"}, core_rst_n, 1'b1);
    endtask

    task automatic power_on(input logic skip);
        @(negedge clk);
        delay_skip = skip;
        #1 pwr_on = 1'b1;
        #1 check("R9 asynchronous assertion on power-on", core_rst_n, 1'b0);
        idle(2);
        pwr_on = 1'b0;
        idle(2);
        check("R1 cause after power-on", rst_cause, 4'b0001);
        check("R1 reset held after power-on", core_rst_n, 1'b0);
    endtask

    task automatic t_power_delay();
        power_on(1'b0);
        ticks(DLY - 1);
        check("R2 held one tick short of delay", core_rst_n, 1'b0);
        last_tick_release("R2/R9");
        check("R1 cause kept after release", rst_cause, 4'b0001);
    endtask

    task automatic t_power_skip();
        power_on(1'b1);
        idle(3);
        check("R3 released with delay skipped", core_rst_n, 1'b1);
        delay_skip = 1'b0;
    endtask

    task automatic t_brownout();
        @(negedge clk) brownout = 1'b1;
        @(negedge clk);
        check("R4 reset asserted on brown-out", core_rst_n, 1'b0);
        ticks(DLY + 3);
        check("R4 held through ticks while flagged", core_rst_n, 1'b0);
        check("R4 brown-out cause", rst_cause, 4'b0010);
        brownout = 1'b0;
        idle(2);
        ticks(DLY - 1);
        check("R2 held one tick short after brown-out", core_rst_n, 1'b0);
        last_tick_release("R2");
    endtask

    task automatic t_brownout_restart();
        @(negedge clk) brownout = 1'b1;
        idle(2);
        brownout = 1'b0;
        idle(2);
        ticks(DLY / 2);
        brownout = 1'b1;
        idle(2);
        brownout = 1'b0;
        idle(2);
        ticks(DLY - 1);
        check("R5 count restarted from zero", core_rst_n, 1'b0);
        last_tick_release("R5");
    endtask

    task automatic t_brownout_skip();
        delay_skip = 1'b1;
        @(negedge clk) brownout = 1'b1;
        idle(3);
        brownout = 1'b0;
        idle(4);
        check("R3 brown-out release without ticks", core_rst_n, 1'b1);
        delay_skip = 1'b0;
    endtask

    task automatic pin_pulse(input int len);
        @(negedge clk) ext_rst_n = 1'b0;
        idle(len);
        ext_rst_n = 1'b1;
    endtask

    task automatic t_pin();
        int base;
        idle(4);
        base = low_cnt;
        pin_pulse(FLT - 1);
        idle(12);
        check("R6 short pin low ignored", low_cnt - base, 0);
        base = low_cnt;
        pin_pulse(FLT);
        idle(12);
        check("R6 pin low at filter length resets", (low_cnt - base) > 0, 1'b1);
        check("R6 pin cause", rst_cause, 4'b0100);
        check("R6 released after pin high without delay", core_rst_n, 1'b1);
    endtask

    task automatic t_pin_disabled();
        int base;
        check("R7 pull-up off with pin enabled", ext_pull_en, 1'b0);
        ext_pin_en = 1'b0;
        idle(4);
        base = low_cnt;
        pin_pulse(20);
        check("R7 pull-up on with pin ignored", ext_pull_en, 1'b1);
        idle(10);
        check("R7 pin low ignored when disabled", low_cnt - base, 0);
        check("R7 cause unchanged", rst_cause, 4'b0100);
        ext_pin_en = 1'b1;
        idle(4);
    endtask

    task automatic t_wdog();
        int base;
        base = low_cnt;
        @(negedge clk) wdog_expire = 1'b1;
        @(negedge clk) wdog_expire = 1'b0;
        check("R8 reset asserted on watchdog", core_rst_n, 1'b0);
        idle(5);
        check("R8 watchdog reset seen", (low_cnt - base) > 0, 1'b1);
        check("R8 released without delay", core_rst_n, 1'b1);
        check("R8 watchdog cause", rst_cause, 4'b1000);
    endtask

    task automatic run_all();
        t_power_delay();
        t_power_skip();
        t_brownout();
        t_brownout_restart();
        t_brownout_skip();
        t_pin();
        t_pin_disabled();
        t_wdog();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (LIMIT) @(posedge clk);
                timeout = 1'b1;
            end
        join_any
        if (timeout) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule